// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-on to a usable state. After reset is released it keeps the clock enable low and the command pins at NOP for a programmable settling interval. It then raises the clock enable and walks the device through a fixed series of commands: a precharge of every bank, eight auto-refresh commands, and a mode-register load. Between commands it waits a programmable number of clock cycles, and at the end it raises a ready flag.

A memory controller instantiates the sequencer beside its normal access engine and hands the command pins over once the ready flag is high. The settling interval, the precharge recovery, the refresh cycle time and the mode-load recovery are input counts in clock cycles. The caller converts its own nanosecond and microsecond figures to cycles. The mode word goes out unchanged on the address bus during the mode-register load. Every delay is timed by one shared down-counter.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While `rst_n` is low the outputs are `o_cke`=0, NOP on the command pins, `o_dqm`=1, `o_addr`=0 and `o_init_done`=0.
- R2: After `rst_n` rises, `o_cke` stays low for max(`i_wait_cycles`,1) cycles, counting the cycle in which reset is released. It then rises one cycle before the precharge, and that cycle carries a NOP.
- R3: The precharge-all command is `{cs_n,ras_n,cas_n,we_n}`=0010 with address bit 10 high and every other address bit low. It follows the clock-enable rise by exactly one cycle.
- R4: The first auto-refresh is issued max(`i_trp`,2) cycles after the precharge.
- R5: Exactly eight auto-refresh commands are issued, encoded 0001 with the address at zero, each max(`i_trc`,2) cycles after the one before it.
- R6: The mode-register load, encoded 0000 with `o_addr` equal to `i_mode`, is issued max(`i_trc`,2) cycles after the eighth refresh.
- R7: `o_init_done` rises and `o_dqm` falls max(`i_tmrd`,2) cycles after the mode-register load.
- R8: Once `o_init_done` is high it stays high and only NOP appears on the command pins until the next reset.
- R9: Every cycle outside a command drives NOP (0111) with `o_addr` at zero.
- R10: Asserting reset part way through the sequence returns all outputs to the R1 state, and the next release runs the whole sequence again from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_wait_cycles | input | CW | Power-up settling interval in cycles, sampled during reset |
| i_trp | input | CW | Precharge recovery in cycles |
| i_trc | input | CW | Refresh cycle time in cycles |
| i_tmrd | input | CW | Mode-load recovery in cycles |
| i_mode | input | AW | Mode word placed on the address bus |
| o_cke | output | 1 | Clock enable |
| o_cs_n | output | 1 | Chip select, active low |
| o_ras_n | output | 1 | Row strobe, active low |
| o_cas_n | output | 1 | Column strobe, active low |
| o_we_n | output | 1 | Write enable, active low |
| o_dqm | output | 1 | Data mask, held high until ready |
| o_addr | output | AW | Address bus |
| o_init_done | output | 1 | Device ready flag |

## Verification
A corrupted delay count or state shows up on the command pins at the next command. That command lands one or more cycles away from the cycle the requirements predict, so the bench compares every cycle against a schedule it computes itself and sees the error at once. A wrong refresh tally gives seven or nine refresh strobes before the mode load, and a wrong ready state gives either a late flag or commands after ready. Several sets of timing counts and a mid-sequence reset make sure that each gap comes from its own input.

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq #(
  parameter int CW = 16,
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] i_wait_cycles,
  input  logic [CW-1:0] i_trp,
  input  logic [CW-1:0] i_trc,
  input  logic [CW-1:0] i_tmrd,
  input  logic [AW-1:0] i_mode,
  output logic          o_cke,
  output logic          o_cs_n,
  output logic          o_ras_n,
  output logic          o_cas_n,
  output logic          o_we_n,
  output logic          o_dqm,
  output logic [AW-1:0] o_addr,
  output logic          o_init_done
);

  localparam int NREF = 8;
  localparam int RW   = $clog2(NREF + 1);
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  typedef enum logic [3:0] {
    S_WAIT, S_CKE, S_PRE, S_GRP, S_REF, S_GRC, S_LMR, S_GMRD, S_DONE
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [RW-1:0] refs;
  logic [3:0]    cmd;
  logic          expired;

  function automatic logic [CW-1:0] gap_load(input logic [CW-1:0] n);
    return (n < CW'(2)) ? CW'(1) : n - CW'(1);
  endfunction

  assign expired = (cnt <= CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_WAIT;
      cnt   <= i_wait_cycles;
      refs  <= '0;
    end else begin
      case (state)
        S_WAIT: if (expired) state <= S_CKE; else cnt <= cnt - CW'(1);
        S_CKE:  state <= S_PRE;
        S_PRE:  begin cnt <= gap_load(i_trp); state <= S_GRP; end
        S_GRP:  if (expired) state <= S_REF; else cnt <= cnt - CW'(1);
        S_REF:  begin cnt <= gap_load(i_trc); refs <= refs + RW'(1); state <= S_GRC; end
        S_GRC:  if (expired) state <= (refs == RW'(NREF)) ? S_LMR : S_REF;
                else cnt <= cnt - CW'(1);
        S_LMR:  begin cnt <= gap_load(i_tmrd); state <= S_GMRD; end
        S_GMRD: if (expired) state <= S_DONE; else cnt <= cnt - CW'(1);
        default: state <= S_DONE;
      endcase
    end
  end

  always_comb begin
    case (state)
      S_PRE:   cmd = C_PRE;
      S_REF:   cmd = C_REF;
      S_LMR:   cmd = C_LMR;
      default: cmd = C_NOP;
    endcase
  end

  assign {o_cs_n, o_ras_n, o_cas_n, o_we_n} = cmd;
  assign o_cke       = (state != S_WAIT);
  assign o_init_done = (state == S_DONE);
  assign o_dqm       = !o_init_done;
  assign o_addr      = (state == S_LMR) ? i_mode :
                       (state == S_PRE) ? AW'(1 << 10) : '0;

  logic [RW:0] chk_refs;
  always_ff @(posedge clk) begin
    if (!rst_n) chk_refs <= '0;
    else if ({o_cs_n, o_ras_n, o_cas_n, o_we_n} == C_REF) chk_refs <= chk_refs + 1'b1;
  end

  p_cke_before_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ({o_cs_n, o_ras_n, o_cas_n, o_we_n} != C_NOP) |-> $past(o_cke));
  p_pre_a10_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ({o_cs_n, o_ras_n, o_cas_n, o_we_n} == C_PRE) |-> (o_addr == AW'(1 << 10)));
  p_pre_then_nop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ({o_cs_n, o_ras_n, o_cas_n, o_we_n} == C_PRE) |=> ({o_cs_n, o_ras_n, o_cas_n, o_we_n} == C_NOP));
  p_ref_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_refs <= (RW + 1)'(NREF));
  p_lmr_after_eight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ({o_cs_n, o_ras_n, o_cas_n, o_we_n} == C_LMR) |-> (chk_refs == (RW + 1)'(NREF) && o_addr == i_mode));
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    o_init_done |=> o_init_done);
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    o_init_done |-> ({o_cs_n, o_ras_n, o_cas_n, o_we_n} == C_NOP && o_cke && !o_dqm));

endmodule

// File: tb/sim_sdram_powerup_seq.sv
module sim_sdram_powerup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int AW = 13;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] wait_c = 5, trp = 2, trc = 3, tmrd = 2;
  logic [AW-1:0] mode = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, dqm, done;
  logic [AW-1:0] addr;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_powerup_seq #(.CW(CW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .i_wait_cycles(wait_c), .i_trp(trp), .i_trc(trc),
    .i_tmrd(tmrd), .i_mode(mode), .o_cke(cke), .o_cs_n(cs_n), .o_ras_n(ras_n),
    .o_cas_n(cas_n), .o_we_n(we_n), .o_dqm(dqm), .o_addr(addr), .o_init_done(done));

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int g2(input int n);
    return (n < 2) ? 2 : n;
  endfunction

  task automatic check_reset_state(input string req);
    check(req, {cke, cs_n, ras_n, cas_n, we_n, dqm, done}, 7'b0011110);
    check(req, addr, 0);
  endtask

  task automatic test_reset;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("R1");
  endtask

  // cycle-by-cycle comparison against a schedule derived from R2..R9
  task automatic run_seq(input int w, input int rp, input int rc, input int mrd,
                         input logic [AW-1:0] md, input int stop_at);
    int ck, pre, lmr, dn, ref0;
    int e_cke = 0, e_pre = 0, e_ref = 0, e_lmr = 0, e_done = 0, e_nop = 0, nref = 0;
    wait_c = CW'(w); trp = CW'(rp); trc = CW'(rc); tmrd = CW'(mrd); mode = md;
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    ck = (w < 1) ? 1 : w;
    pre = ck + 1;
    ref0 = pre + g2(rp);
    lmr = ref0 + 8 * g2(rc);
    dn = lmr + g2(mrd);
    for (int k = 1; k <= dn + 12; k++) begin
      logic [3:0] c;
      @(negedge clk);
      if (stop_at != 0 && k == stop_at) begin
        rst_n = 0;
        @(posedge clk);
        @(negedge clk);
        check_reset_state("R10");
        return;
      end
      c = {cs_n, ras_n, cas_n, we_n};
      if (cke !== (k >= ck)) e_cke++;
      if (k == pre) begin
        if (c !== 4'b0010 || addr !== AW'(1 << 10)) e_pre++;
      end else if (k >= ref0 && k < lmr && ((k - ref0) % g2(rc)) == 0) begin
        nref++;
        if (c !== 4'b0001 || addr !== 0) e_ref++;
      end else if (k == lmr) begin
        if (c !== 4'b0000 || addr !== md) e_lmr++;
      end else if (c !== 4'b0111 || addr !== 0) e_nop++;
      if (done !== (k >= dn) || dqm !== (k < dn)) e_done++;
    end
    check("R2 cke timing errors", e_cke, 0);
    check("R3 precharge errors", e_pre, 0);
    check("R4/R5 refresh slot errors", e_ref, 0);
    check("R5 refresh count", nref, 8);
    check("R6 mode load errors", e_lmr, 0);
    check("R7 ready/dqm errors", e_done, 0);
    check("R9 nop errors", e_nop, 0);
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      if (!(done && {cs_n, ras_n, cas_n, we_n} == 4'b0111)) e_done++;
    end
    check("R8 quiet after ready", e_done, 0);
  endtask

  initial begin
    test_reset();
    run_seq(5, 2, 3, 2, 13'h0123, 0);
    run_seq(20, 4, 7, 5, 13'h1FFF, 0);
    run_seq(2, 1, 0, 1, 13'h0A5A, 0);
    run_seq(9, 3, 4, 3, 13'h0037, 30);
    run_seq(9, 3, 4, 3, 13'h0037, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule